// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer reached through four 32-bit registers on a simple single-cycle register bus. The bus decodes byte address bits 3:2. A selectable prescaler divides the clock into ticks, and a down-counter counts those ticks. Software arms the counter by writing one exact restart code. The counter then reloads from a coarse 12-bit field scaled by 4096. If software stops restarting it and the counter reaches zero, the block raises a sticky status flag. It can also raise a level interrupt, drive an active-high reset pulse of programmable length, or do both.

Each configuration register has its own access key carried in the upper bits of the write data, so a stray store cannot disarm or retune the watchdog. A write without the right key leaves the register as it was. The status register also shows the live counter value, so software and the bench can watch the count fall.

Top module: `guard_timer`

## Requirements
- R1: A write at offset 0x0 (setup register) takes effect only when write-data bits 23:12 equal 0xABC. Bit 0 is arm, bit 1 is reset-enable, bit 2 is interrupt-enable and bits 5:4 are the pulse-length code. A read returns these fields in the same positions, with all other bits zero.
- R2: A write at offset 0x4 (timing register) takes effect only when `wdata & 0xFFFFC000` equals 0x00920000. Bits 13:2 are the 12-bit reload field and bits 1:0 are the prescaler select. A read returns bits 13:0, with all other bits zero.
- R3: A write of exactly 0x00001999 at offset 0x8 loads the counter with reload×4096, clears the status flag and drops the interrupt. Any other value written there is ignored. Reads of offset 0x8 return zero.
- R4: Prescaler select values 0, 1, 2 and 3 give one counter decrement every 8, 64, 512 and 4096 clocks. Counting starts from the restart edge, and the count reads back in status bits 31:8.
- R5: While armed, the counter reaching zero sets status bit 0 (offset 0xC) on the next clock edge. The counter then holds at zero until a restart.
- R6: `wdt_irq` is high exactly while the status flag is set and interrupt-enable is 1.
- R7: With reset-enable set, expiry makes `wdt_rst` high for 2, 4, 8 or 16 cycles for length codes 0 to 3, starting the cycle after the expiry edge. With reset-enable clear, `wdt_rst` stays low.
- R8: While disarmed, the counter does not decrement and no expiry occurs. A restart still loads the counter.
- R9: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data including key or code |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst | output | 1 | Active-high reset pulse on expiry |
| wdt_irq | output | 1 | Interrupt level on expiry |

## Verification
The bench tries random wrong keys against both configuration registers and looks for corrupted readback, which a missing or partial key compare would show. It also writes near-miss restart values and checks that they neither clear the flag nor reload the count. For each pulse-length code it counts the cycles that the reset pulse stays high, which catches an off-by-one in the length decode. A full expiry at the smallest non-zero reload is timed to the exact clock, where a mis-scaled reload or an early expiry edge would land on the wrong cycle. Random prescaler selects and wait times catch a prescaler that divides by the wrong ratio or does not restart its phase on a restart.

// File: rtl/guard_timer_pkg.sv
// Package: shared register selects, key constants and register layouts for
// the keyed watchdog. Assumes a 32-bit bus data path.
package guard_timer_pkg;

    localparam int unsigned RELOAD_W = 12;

    typedef enum logic [1:0] {
        SEL_SETUP  = 2'd0,
        SEL_TIMING = 2'd1,
        SEL_KICK   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    localparam logic [11:0] SETUP_KEY  = 12'hABC;
    localparam logic [17:0] TIMING_KEY = 18'h00248;
    localparam logic [31:0] KICK_CODE  = 32'h0000_1999;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       arm;
    } setup_t;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [1:0]          psel;
    } timing_t;

endpackage

// File: rtl/guard_timer_regs.sv
// Register file: decodes the bus, checks the per-register keys and the
// restart code, and muxes read data. Assumes single-cycle write strobes and
// that COUNT_W fits in status bits 31:8.
module guard_timer_regs
    import guard_timer_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned COUNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [COUNT_W-1:0] count,
    input  logic               expired,
    output logic [31:0]        bus_rdata,
    output setup_t             setup_q,
    output timing_t            timing_q,
    output logic               kick
);

    reg_sel_e sel;
    logic     setup_ok;
    logic     timing_ok;
    logic [31:0] status_word;

    // Register select from word address bits.
    assign sel       = reg_sel_e'(bus_addr[3:2]);
    assign setup_ok  = bus_wr && (sel == SEL_SETUP)  && (bus_wdata[23:12] == SETUP_KEY);
    assign timing_ok = bus_wr && (sel == SEL_TIMING) && (bus_wdata[31:14] == TIMING_KEY);
    assign kick      = bus_wr && (sel == SEL_KICK)   && (bus_wdata == KICK_CODE);

    // Setup register: keyed update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
        end else if (setup_ok) begin
            setup_q <= '{plen: bus_wdata[5:4], irq_en: bus_wdata[2],
                         rst_en: bus_wdata[1], arm: bus_wdata[0]};
        end
    end

    // Timing register: keyed update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= '0;
        end else if (timing_ok) begin
            timing_q <= '{reload: bus_wdata[13:2], psel: bus_wdata[1:0]};
        end
    end

    // Status word: flag in bit 0, live count from bit 8.
    always_comb begin
        status_word = '0;
        status_word[0] = expired;
        status_word[8 +: COUNT_W] = count;
    end

    // Read mux with key fields returned as zero.
    always_comb begin
        unique case (sel)
            SEL_SETUP:  bus_rdata = {26'd0, setup_q.plen, 1'b0, setup_q.irq_en,
                                     setup_q.rst_en, setup_q.arm};
            SEL_TIMING: bus_rdata = {18'd0, timing_q.reload, timing_q.psel};
            SEL_KICK:   bus_rdata = '0;
            default:    bus_rdata = status_word;
        endcase
    end

    // R1
    setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (sel == SEL_SETUP)) |=> $stable(setup_q));

    // R2
    timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (sel == SEL_TIMING)) |=> $stable(timing_q));

endmodule

// File: rtl/guard_timer_prescale.sv
// Prescaler: produces one tick every 2^(STEP_LOG2*(psel+1)) clocks while
// run is high. Its phase restarts on clear or whenever run is low.
module guard_timer_prescale #(
    parameter int unsigned STEP_LOG2 = 3,
    parameter int unsigned PRE_W     = STEP_LOG2 * 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] psel,
    output logic       tick
);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;

    // Terminal count for the selected division ratio.
    assign lim  = PRE_W'((32'd1 << (STEP_LOG2 * (32'(psel) + 32'd1))) - 32'd1);
    assign tick = run && !clear && (pre >= lim);

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clear || !run || (pre >= lim)) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/guard_timer_count.sv
// Down-counter and sticky expiry flag. A restart loads reload scaled by
// 2^SCALE_LOG2 and takes priority over expiry and decrement.
module guard_timer_count #(
    parameter int unsigned RELOAD_W   = 12,
    parameter int unsigned SCALE_LOG2 = 12,
    parameter int unsigned COUNT_W    = RELOAD_W + SCALE_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                kick,
    input  logic                tick,
    input  logic [RELOAD_W-1:0] reload,
    output logic [COUNT_W-1:0]  count,
    output logic                expired,
    output logic                expire_evt
);

    assign expire_evt = arm && (count == '0) && !expired && !kick;

    // Counter load and decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (kick) begin
            count <= {reload, {SCALE_LOG2{1'b0}}};
        end else if (tick && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expired <= 1'b0;
        end else if (kick) begin
            expired <= 1'b0;
        end else if (expire_evt) begin
            expired <= 1'b1;
        end
    end

    // R3
    kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == {$past(reload), {SCALE_LOG2{1'b0}}}) && !expired);

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !kick) |=> (count == '0));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !kick) |=> $stable(count) && $stable(expired));

endmodule

// File: rtl/guard_timer_pulse.sv
// Reset pulse generator: on fire, drives pulse high for 2^(plen+1) cycles.
// Assumes fire is a single-cycle strobe.
module guard_timer_pulse #(
    parameter int unsigned LEN_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [1:0] plen,
    output logic       pulse
);

    logic [LEN_W-1:0] left;
    logic [LEN_W-1:0] run_len;

    assign pulse = (left != '0);

    // Remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (fire) begin
            left <= LEN_W'(2) << plen;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    // Checker: length of the current high run.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse) begin
            run_len <= '0;
        end else if (run_len != '1) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R7
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(fire));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (run_len < LEN_W'(16)));

endmodule

// File: rtl/guard_timer.sv
// Keyed watchdog top: register file, prescaler, counter and reset pulse.
// Assumes a synchronous active-low reset and single-cycle bus writes.
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned SCALE_LOG2 = 12,
    parameter int unsigned STEP_LOG2  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst,
    output logic              wdt_irq
);

    localparam int unsigned COUNT_W = RELOAD_W + SCALE_LOG2;

    setup_t             setup_q;
    timing_t            timing_q;
    logic               kick;
    logic               tick;
    logic               expired;
    logic               expire_evt;
    logic [COUNT_W-1:0] count;

    guard_timer_regs #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .expired(expired),
        .bus_rdata(bus_rdata), .setup_q(setup_q), .timing_q(timing_q), .kick(kick)
    );

    guard_timer_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(setup_q.arm && (count != '0)),
        .clear(kick), .psel(timing_q.psel), .tick(tick)
    );

    guard_timer_count #(.RELOAD_W(RELOAD_W), .SCALE_LOG2(SCALE_LOG2)) u_cnt (
        .clk(clk), .rst_n(rst_n), .arm(setup_q.arm), .kick(kick), .tick(tick),
        .reload(timing_q.reload), .count(count), .expired(expired),
        .expire_evt(expire_evt)
    );

    guard_timer_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire_evt && setup_q.rst_en),
        .plen(setup_q.plen), .pulse(wdt_rst)
    );

    // Interrupt level follows the sticky flag.
    assign wdt_irq = expired && setup_q.irq_en;

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |-> expired);

endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst;
    logic        wdt_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    guard_timer i_guard_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_count(int rl, int ps, int k);
        int v;
        v = rl * 4096 - (k >> (3 * (ps + 1)));
        if (v < 0) v = 0;
        return 32'(v);
    endfunction

    function automatic int exp_len(int code);
        return 2 << code;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d, shadow_setup, shadow_timing, v;
        int seed;
        seed = int'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), d);
            check("R9 reg", d, 32'd0);
        end
        check("R9 rst", {31'd0, wdt_rst}, 32'd0);
        check("R9 irq", {31'd0, wdt_irq}, 32'd0);

        // R1 keyed and unkeyed setup writes (arm kept clear)
        shadow_setup = 0;
        for (int i = 0; i < 12; i++) begin
            v = $urandom & 32'hFF000FFE;
            if (i % 2 == 0) begin
                wr(4'h0, v | 32'h00ABC000);
                shadow_setup = v & 32'h37;
            end else begin
                logic [31:0] key;
                key = {20'd0, 12'($urandom)};
                if (key[11:0] == 12'hABC) key = 32'h0ABD;
                wr(4'h0, v | (key << 12));
            end
            rd(4'h0, d);
            check("R1 setup readback", d, shadow_setup);
        end

        // R2 keyed and unkeyed timing writes
        shadow_timing = 0;
        for (int i = 0; i < 12; i++) begin
            v = $urandom & 32'h3FFF;
            if (i % 2 == 0) begin
                wr(4'h4, v | 32'h00920000);
                shadow_timing = v;
            end else if (i == 3) begin
                wr(4'h4, v | 32'h01920000);
            end else begin
                wr(4'h4, v | (($urandom & 32'hFFFFC000) ^ 32'h00124000));
            end
            rd(4'h4, d);
            check("R2 timing readback", d, shadow_timing);
        end
        rd(4'h8, d);
        check("R3 restart reads zero", d, 32'd0);

        // R8 disarmed: restart loads, no decrement
        wr(4'h0, 32'h00ABC000);
        wr(4'h4, 32'h00920000 | (32'd1 << 2));
        wr(4'h8, 32'h1999);
        repeat (100) @(negedge clk);
        rd(4'hC, d);
        check("R8 count frozen", d, exp_count(1, 0, 0) << 8);
        wr(4'h4, 32'h00920000 | (32'd2 << 2));
        wr(4'h8, 32'h1998);
        wr(4'h8, 32'h00011999);
        rd(4'hC, d);
        check("R3 wrong code no reload", d, exp_count(1, 0, 0) << 8);

        // R4 random prescaler trials, armed
        wr(4'h8, 32'h1999);
        wr(4'h0, 32'h00ABC001);
        for (int t = 0; t < 8; t++) begin
            int ps, rl, k;
            ps = (t < 4) ? t : int'($urandom_range(3, 0));
            rl = int'($urandom_range(3, 1));
            k  = int'($urandom_range(8000, 1));
            wr(4'h4, 32'h00920000 | 32'(rl << 2) | 32'(ps));
            wr(4'h8, 32'h1999);
            repeat (k) @(negedge clk);
            rd(4'hC, d);
            check("R4 count after wait", d, exp_count(rl, ps, k) << 8);
            wr(4'h8, 32'h1999);
            rd(4'hC, d);
            check("R3 reload value", d, exp_count(rl, ps, 0) << 8);
        end

        // R5 boundary: reload 1, divide by 8
        wr(4'h4, 32'h00920000 | (32'd1 << 2));
        wr(4'h0, 32'h00ABC005);
        wr(4'h8, 32'h1999);
        repeat (32768) @(negedge clk);
        rd(4'hC, d);
        check("R5 zero not yet expired", d, 32'd0);
        check("R6 irq low before expiry", {31'd0, wdt_irq}, 32'd0);
        @(negedge clk);
        rd(4'hC, d);
        check("R5 flag set", d, 32'd1);
        check("R6 irq high", {31'd0, wdt_irq}, 32'd1);
        check("R7 no pulse when disabled", {31'd0, wdt_rst}, 32'd0);

        // R7 pulse length per code, R6 irq, R3 wrong restart
        for (int code = 0; code < 4; code++) begin
            int n;
            wr(4'h4, 32'h00920000 | 32'($urandom_range(3, 0)));
            wr(4'h0, 32'h00ABC007 | 32'(code << 4));
            wr(4'h8, 32'h1999);
            @(negedge clk);
            rd(4'hC, d);
            check("R5 immediate expiry", d, 32'd1);
            n = 0;
            while (wdt_rst && n < 40) begin
                n++;
                @(negedge clk);
            end
            check("R7 pulse length", 32'(n), 32'(exp_len(code)));
            check("R6 irq holds", {31'd0, wdt_irq}, 32'd1);
            wr(4'h8, 32'h0000_1990);
            rd(4'hC, d);
            check("R3 bad restart keeps flag", d, 32'd1);
        end

        // R6 irq gated off while reset enabled
        wr(4'h0, 32'h00ABC003);
        wr(4'h8, 32'h1999);
        @(negedge clk);
        check("R6 irq masked", {31'd0, wdt_irq}, 32'd0);
        check("R7 pulse present", {31'd0, wdt_rst}, 32'd1);

        // R8 stop then restart: nothing fires
        wr(4'h0, 32'h00ABC006);
        wr(4'h8, 32'h1999);
        repeat (20) @(negedge clk);
        rd(4'hC, d);
        check("R8 no expiry when disarmed", d, 32'd0);
        check("R8 irq low", {31'd0, wdt_irq}, 32'd0);
        check("R8 rst low", {31'd0, wdt_rst}, 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule